// File: doc/BRIEF.md
# Two-Pulse Gated Test Clock Generator

This block produces a short, exact burst of clock edges for at-speed capture. A select input picks either the slow test clock or a faster on-chip clock. When the slow-clock side raises an apply-and-capture request, the block emits exactly two full pulses of the selected clock on a gated output and keeps that output low at all other times. The gated output clocks the apply and capture registers of the test ports and the internal registers of the circuit under test.

The request is driven in the slow-clock domain. It passes through a chain of synchronizer flops clocked by the selected clock. Its synchronized rising edge then starts a short enable sequence that is exactly two selected-clock cycles long. A gate latch is transparent while the selected clock is low, and the gate combines the clock with that latched enable, so the burst contains no partial pulses. A busy output tells the controller when the clock selection may be changed.

Top module: `dual_pulse_clkgen`

## Requirements
- R1: While reset is asserted and after reset until the first request, `clk_out` stays low and `busy` is 0.
- R2: With `clk_sel` = 0 the pulses on `clk_out` are those of `tclk`. With `clk_sel` = 1 they are those of `hfclk`. The two pulses of a burst are one selected-clock period apart.
- R3: Only the rising edge of the request starts a burst. A request held high for any number of slow cycles (two or more) produces one burst.
- R4: The request crosses into the selected domain through SYNC_STAGES flops. The internal burst enable is then high for exactly two consecutive selected-clock cycles.
- R5: Each accepted request yields exactly two rising edges on `clk_out`, and `clk_out` is low between bursts.
- R6: Each pulse on `clk_out` is a full high phase of the selected clock: its high time equals half the selected period, with no runt or glitch.
- R7: A synchronized rising edge that arrives in the selected-clock cycle right after the burst enable ends (the guard cycle) is dropped. With the test clock selected, a request pattern of 2 high, 1 low, 2 high cycles gives 2 pulses in total. A pattern of 2 high, 2 low, 2 high gives 4 pulses.
- R8: `busy` is 1 while the request is high and while any synchronizer, burst or guard stage is active. It returns to 0 once the burst is over. `clk_sel` may change only while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tclk | input | 1 | Slow test clock; the request is driven in this domain |
| hfclk | input | 1 | High-frequency on-chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 0 selects `tclk`, 1 selects `hfclk` |
| aac_req | input | 1 | Apply-and-capture request strobe |
| clk_out | output | 1 | Gated burst clock, two pulses per accepted request |
| busy | output | 1 | High while a request is in flight or a burst is running |

## Verification
The bench sweeps both clock selections and several fast-clock periods. For each case it measures how many pulses a burst has, how far apart they are and how long each stays high. A design without edge detection would repeat the burst for a long strobe. A design without the gate latch would produce runt or extra pulses. The back-to-back request patterns target the guard cycle: a missing guard gives four pulses where two are expected, and a guard that is too long drops a legitimate second request. `busy` is checked during a request and after it, because a flag that clears early would allow the clock selection to change in the middle of a burst.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    // number of selected-clock cycles the gate enable is held
    localparam int BURST_CYCLES = 2;
    // cycles after the burst during which a new edge is refused
    localparam int GUARD_CYCLES = 1;
    localparam int SEQ_LEN      = BURST_CYCLES + GUARD_CYCLES;

    typedef struct packed {
        logic               prev;   // delayed synchronized request
        logic [SEQ_LEN-1:0] seq;    // one-hot travelling burst token
    } burst_state_t;
endpackage

// File: rtl/dpc_sync.sv
module dpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic any_high
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (STAGES == 1) begin
            chain_d[0] = din;
        end else begin
            chain_d = {chain_q[STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout     = chain_q[STAGES-1];
    assign any_high = |chain_q;
endmodule

// File: rtl/dpc_burst.sv
module dpc_burst
    import dpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    output logic burst_en,
    output logic burst_hold,
    output logic prev_high
);
    burst_state_t st_d, st_q;
    logic         edge_seen;
    logic         accept;

    always_comb begin
        st_d      = st_q;
        edge_seen = req_sync & ~st_q.prev;
        accept    = edge_seen & ~(|st_q.seq);
        st_d.prev = req_sync;
        if (SEQ_LEN == 1) begin
            st_d.seq[0] = accept;
        end else begin
            st_d.seq = {st_q.seq[SEQ_LEN-2:0], accept};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign burst_en   = |st_q.seq[BURST_CYCLES-1:0];
    assign burst_hold = |st_q.seq;
    assign prev_high  = st_q.prev;
endmodule

// File: rtl/dpc_gate.sv
module dpc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic gclk,
    output logic en_latched
);
    logic lat_q;

    // transparent during the low phase: enable changes after a rising edge
    // are held off until the clock has fallen again
    always_latch begin
        if (!rst_n)    lat_q = 1'b0;
        else if (!clk) lat_q = en;
    end

    assign gclk       = clk & lat_q;
    assign en_latched = lat_q;
endmodule

// File: rtl/dual_pulse_clkgen.sv
module dual_pulse_clkgen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic tclk,
    input  logic hfclk,
    input  logic rst_n,
    input  logic clk_sel,
    input  logic aac_req,
    output logic clk_out,
    output logic busy
);
    logic sel_clk;
    logic req_sync;
    logic sync_active;
    logic burst_en;
    logic burst_hold;
    logic prev_high;
    logic gate_open;

    assign sel_clk = clk_sel ? hfclk : tclk;

    dpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (sel_clk),
        .rst_n    (rst_n),
        .din      (aac_req),
        .dout     (req_sync),
        .any_high (sync_active)
    );

    dpc_burst u_burst (
        .clk        (sel_clk),
        .rst_n      (rst_n),
        .req_sync   (req_sync),
        .burst_en   (burst_en),
        .burst_hold (burst_hold),
        .prev_high  (prev_high)
    );

    dpc_gate u_gate (
        .clk        (sel_clk),
        .rst_n      (rst_n),
        .en         (burst_en),
        .gclk       (clk_out),
        .en_latched (gate_open)
    );

    assign busy = aac_req | sync_active | prev_high | burst_hold | gate_open;
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker (
    input logic sel_clk,
    input logic rst_n,
    input logic clk_sel,
    input logic burst_en,
    input logic burst_hold,
    input logic busy
);
    AST_BURST_SECOND_CYCLE: assert property (@(posedge sel_clk) disable iff (!rst_n)
        $rose(burst_en) |=> burst_en);                          // R4
    AST_BURST_ENDS: assert property (@(posedge sel_clk) disable iff (!rst_n)
        $rose(burst_en) |=> ##1 !burst_en);                     // R4
    AST_GUARD_AFTER_BURST: assert property (@(posedge sel_clk) disable iff (!rst_n)
        $fell(burst_en) |=> !burst_en);                         // R7
    AST_BUSY_DURING_BURST: assert property (@(posedge sel_clk) disable iff (!rst_n)
        burst_hold |-> busy);                                   // R8
    AST_SEL_HELD_IN_BURST: assert property (@(posedge sel_clk) disable iff (!rst_n)
        burst_en |-> $stable(clk_sel));                         // R8
endmodule

bind dual_pulse_clkgen dpc_checker u_chk (
    .sel_clk    (sel_clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .burst_en   (burst_en),
    .burst_hold (burst_hold),
    .busy       (busy)
);

// File: tb/dual_pulse_clkgen_tb_top.sv
`timescale 1ns/1ps
module dual_pulse_clkgen_tb_top;
    logic tclk = 1'b0;
    logic hfclk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_sel = 1'b0;
    logic aac_req = 1'b0;
    logic clk_out;
    logic busy;

    int      checks = 0;
    int      errors = 0;
    realtime hf_half = 1.5;
    bit      finished = 0;

    int      pcnt = 0;
    realtime t_prev = 0.0, t_last = 0.0, t_width = 0.0;

    dual_pulse_clkgen #(.SYNC_STAGES(2)) dut_i (
        .tclk(tclk), .hfclk(hfclk), .rst_n(rst_n), .clk_sel(clk_sel),
        .aac_req(aac_req), .clk_out(clk_out), .busy(busy)
    );

    always #5 tclk = ~tclk;
    initial forever #(hf_half) hfclk = ~hfclk;

    always @(posedge clk_out) begin
        pcnt   = pcnt + 1;
        t_prev = t_last;
        t_last = $realtime;
    end
    always @(negedge clk_out) t_width = $realtime - t_last;

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_time(string tag, realtime act, realtime exp);
        checks++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            errors++;
            $display("FAIL %s actual %0.3f expected %0.3f", tag, act, exp);
        end
    endtask

    task automatic req_high(int n);
        @(negedge tclk) aac_req = 1'b1;
        repeat (n - 1) @(negedge tclk);
        @(negedge tclk) aac_req = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge tclk);
    endtask

    // single burst: count, spacing, width, busy afterwards
    task automatic one_burst(int width, realtime period, string tag);
        int base;
        base = pcnt;
        @(negedge tclk) aac_req = 1'b1;
        #1 check_int({tag, " R8 busy while request"}, int'(busy), 1);
        repeat (width - 1) @(negedge tclk);
        @(negedge tclk) aac_req = 1'b0;
        idle(12);
        check_int({tag, " R5 pulse count"}, pcnt - base, 2);
        check_time({tag, " R2 pulse spacing"}, t_last - t_prev, period);
        check_time({tag, " R6 pulse high time"}, t_width, period / 2.0);
        check_int({tag, " R5 clk_out low between bursts"}, int'(clk_out), 0);
        check_int({tag, " R8 busy cleared"}, int'(busy), 0);
    endtask

    initial begin
        int base;
        realtime hf_tab [3] = '{1.5, 2.0, 3.5};
        #1;
        check_int("R1 clk_out in reset", int'(clk_out), 0);
        check_int("R1 busy in reset", int'(busy), 0);
        idle(3);
        rst_n = 1'b1;
        idle(5);
        check_int("R1 no pulses after reset", pcnt, 0);
        check_int("R1 busy after reset", int'(busy), 0);

        // slow clock selected
        clk_sel = 1'b0;
        one_burst(2, 10.0, "tclk w2");
        one_burst(5, 10.0, "tclk w5 R3");

        // back-to-back patterns against the guard cycle
        base = pcnt;
        req_high(2); // gap 1 then second
        @(negedge tclk) aac_req = 1'b1;
        @(negedge tclk);
        @(negedge tclk) aac_req = 1'b0;
        idle(12);
        check_int("R7 gap1 second request dropped", pcnt - base, 2);

        base = pcnt;
        @(negedge tclk) aac_req = 1'b1;
        @(negedge tclk);
        @(negedge tclk) aac_req = 1'b0;
        @(negedge tclk);
        @(negedge tclk) aac_req = 1'b1;
        @(negedge tclk);
        @(negedge tclk) aac_req = 1'b0;
        idle(12);
        check_int("R7 gap2 second request accepted", pcnt - base, 4);

        // fast clock selected, several periods
        clk_sel = 1'b1;
        foreach (hf_tab[i]) begin
            hf_half = hf_tab[i];
            idle(4);
            one_burst(2, 2.0 * hf_tab[i], $sformatf("hf p%0.1f", 2.0 * hf_tab[i]));
            one_burst(4, 2.0 * hf_tab[i], $sformatf("hf p%0.1f long R3", 2.0 * hf_tab[i]));
        end

        // switch back while idle
        clk_sel = 1'b0;
        idle(4);
        one_burst(3, 10.0, "reselect tclk R2");

        base = pcnt;
        idle(20);
        check_int("R5 no pulses without request", pcnt - base, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule